// File: doc/BRIEF.md
# Expanding-opcode instruction decoder

This block decodes one 16-bit instruction word per evaluation, with no clock and no state. The format has an opcode that grows. The top nibble names a two-operand operation unless it is all ones. In that case the next six bits name the operation, unless they are also all ones. Then the lowest six bits name it. Conditional branches are a special case: they pack a 3-bit condition and an 8-bit signed displacement into the bits below the top nibble.

The decoder places each word in exactly one class: two-operand, one-operand, zero-operand or illegal. It drives a one-hot strobe with one bit per operation. It extracts the operand specifiers, the interrupt mask value, the condition code and the sign-extended branch offset. A field that does not belong to the decoded operation reads as zero. An unassigned code raises only the illegal class, and it drives no strobe and no field. The outputs feed the operand-fetch and execute stages.

Top module: `instr_decoder`

## Requirements
- R1: For every 16-bit input, exactly one of isTwoOp, isOneOp, isZeroOp and isIllegal is 1.
- R2: Bits 15-12 of 0-8 give a two-operand operation. Strobe bits 0-8 stand for LD, ADD, ADC, SUB, SBC, CMP, AND, OR, XOR in that order. opnd2Spec equals bits 11-6 and opnd1Spec equals bits 5-0.
- R3: Bits 15-12 with a value from 9 to 14 give an illegal word.
- R4: Bits 15-12 = 15 with bits 11-6 from 0 to 12 give a one-operand operation. Strobe bits 9-21 stand for NOT, NEG, INC, DEC, RR, RRC, RL, RLC, SRA, SRL, SL, SLB, SRB in that order. opnd1Spec equals bits 5-0 and opnd2Spec is 0.
- R5: Bits 15-12 = 15 with bits 11-6 of 13-15 or of 18-31 give an illegal word.
- R6: Bits 15-12 = 15 with bits 11-6 = 16 give the mask-set operation (strobe bit 22). Bits 11-6 = 17 give the software trap (strobe bit 23). Both belong to the one-operand class, and maskVal equals bits 5-0.
- R7: Bits 15-12 = 15 with bit 11 = 1 and bits 11-6 not 63 give a branch (strobe bit 24, one-operand class). condCode equals bits 10-8, and branchOffset is bits 7-0 sign-extended.
- R8: Bits 15-6 all ones with bits 5-0 from 0 to 4 give the zero-operand operations. Strobe bits 25-29 stand for SETC, CLRC, RTS, RTI, NOP in that order.
- R9: Bits 15-6 all ones give a jump when bits 5-3 are 100 (strobe bit 30) and a subroutine call when they are 101 (strobe bit 31). Both are zero-operand, and condCode equals bits 2-0.
- R10: Bits 15-6 all ones with bits 5-0 from 5 to 31 or of the form 11xxxx give an illegal word.
- R11: opStrobe has exactly one bit set for a legal word and is zero for an illegal one. Any field output that the decoded operation does not use reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 16 | Instruction word to decode |
| isTwoOp | output | 1 | Two-operand class |
| isOneOp | output | 1 | One-operand class, including mask-set, trap and branch |
| isZeroOp | output | 1 | Zero-operand class |
| isIllegal | output | 1 | Unassigned code |
| opStrobe | output | 32 | One-hot operation strobe |
| opnd1Spec | output | 6 | Operand-1 mode and register specifier |
| opnd2Spec | output | 6 | Operand-2 mode and register specifier |
| maskVal | output | 6 | Mask value for mask-set and trap |
| condCode | output | 3 | Condition for branch, jump and call |
| branchOffset | output | OFFSET_W | Sign-extended branch displacement |

## Verification
Assertions placed beside the logic check, on every evaluation, the structural rules: the class is one-hot, the strobe is one-hot and matches the class, and an illegal word drives no field. They also check that the branch offset is a sign extension of the low byte. These rules cannot show that a given code maps to the right operation. Only the bench's table of words can show that, at the boundaries of each code range: 8 against 9, 12 against 13, 17 against 18, 4 against 5, and the 111110 pattern that is still a branch. An exhaustive sweep of all 65536 words covers the class and strobe rules at the ports.

// File: rtl/instr_decoder_pkg.sv
package instr_decoder_pkg;

  localparam int WORD_W   = 16;
  localparam int TOP_W    = 4;
  localparam int FIELD_W  = 6;
  localparam int COND_W   = 3;
  localparam int DISP_W   = 8;
  localparam int NUM_OPS  = 32;
  localparam int OP_IDX_W = $clog2(NUM_OPS);

  // Last assigned codes in each group
  localparam int TWO_OP_LAST  = 8;
  localparam int ONE_OP_LAST  = 12;
  localparam int ZERO_OP_LAST = 4;
  localparam logic [FIELD_W-1:0] MID_MASKSET = 6'd16;
  localparam logic [FIELD_W-1:0] MID_TRAP    = 6'd17;
  localparam logic [FIELD_W-1:0] ALL_ONES6   = '1;
  localparam logic [TOP_W-1:0]   ALL_ONES4   = '1;

  typedef enum logic [OP_IDX_W-1:0] {
    OP_LD, OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_AND, OP_OR, OP_XOR,
    OP_NOT, OP_NEG, OP_INC, OP_DEC, OP_RR, OP_RRC, OP_RL, OP_RLC,
    OP_SRA, OP_SRL, OP_SL, OP_SLB, OP_SRB,
    OP_MASKSET, OP_TRAP, OP_BRA,
    OP_SETC, OP_CLRC, OP_RTS, OP_RTI, OP_NOP,
    OP_JMP, OP_JSR
  } opId_t;

  typedef enum logic [1:0] {
    CLS_TWO  = 2'd0,
    CLS_ONE  = 2'd1,
    CLS_ZERO = 2'd2,
    CLS_ILL  = 2'd3
  } instrClass_t;

  // Strobes from control to datapath: which fields to pass through
  typedef struct packed {
    logic takeOp1;
    logic takeOp2;
    logic takeMask;
    logic takeBrCond;
    logic takeJmpCond;
    logic takeDisp;
  } fieldSel_t;

endpackage

// File: rtl/instr_decoder_ctrl.sv
module instr_decoder_ctrl
  import instr_decoder_pkg::*;
(
  input  logic [TOP_W-1:0]   topField,
  input  logic [FIELD_W-1:0] midField,
  input  logic [FIELD_W-1:0] lowField,
  output instrClass_t        instrClass,
  output opId_t              opIdx,
  output logic               opValid,
  output fieldSel_t          fieldSel
);

  logic topIsOnes;
  logic midIsOnes;

  assign topIsOnes = (topField == ALL_ONES4);
  assign midIsOnes = (midField == ALL_ONES6);

  always_comb begin
    instrClass = CLS_ILL;
    opIdx      = OP_LD;
    opValid    = 1'b0;
    fieldSel   = '0;

    if (!topIsOnes) begin
      // two-operand group
      if (topField <= TOP_W'(TWO_OP_LAST)) begin
        instrClass       = CLS_TWO;
        opIdx            = opId_t'(OP_IDX_W'(topField));
        opValid          = 1'b1;
        fieldSel.takeOp1 = 1'b1;
        fieldSel.takeOp2 = 1'b1;
      end
    end else if (midIsOnes) begin
      // zero-operand group
      if (lowField[5:4] == 2'b10) begin
        instrClass           = CLS_ZERO;
        opIdx                = lowField[3] ? OP_JSR : OP_JMP;
        opValid              = 1'b1;
        fieldSel.takeJmpCond = 1'b1;
      end else if (lowField <= FIELD_W'(ZERO_OP_LAST)) begin
        instrClass = CLS_ZERO;
        opIdx      = opId_t'(OP_IDX_W'(OP_SETC) + OP_IDX_W'(lowField[2:0]));
        opValid    = 1'b1;
      end
    end else if (midField[5]) begin
      // branch: condition and displacement packed below the top nibble
      instrClass          = CLS_ONE;
      opIdx               = OP_BRA;
      opValid             = 1'b1;
      fieldSel.takeBrCond = 1'b1;
      fieldSel.takeDisp   = 1'b1;
    end else if (midField <= FIELD_W'(ONE_OP_LAST)) begin
      instrClass       = CLS_ONE;
      opIdx            = opId_t'(OP_IDX_W'(OP_NOT) + OP_IDX_W'(midField[3:0]));
      opValid          = 1'b1;
      fieldSel.takeOp1 = 1'b1;
    end else if (midField == MID_MASKSET || midField == MID_TRAP) begin
      instrClass        = CLS_ONE;
      opIdx             = midField[0] ? OP_TRAP : OP_MASKSET;
      opValid           = 1'b1;
      fieldSel.takeMask = 1'b1;
    end
  end

  // R1
  always_comb begin
    ctrl_valid_class_chk: assert (opValid == (instrClass != CLS_ILL))
      else $error("valid flag disagrees with class");
  end

  // R11
  always_comb begin
    if (!opValid) begin
      ctrl_illegal_nosel_chk: assert (fieldSel == '0)
        else $error("illegal word selects a field");
    end
  end

endmodule

// File: rtl/instr_decoder_fields.sv
module instr_decoder_fields
  import instr_decoder_pkg::*;
#(
  parameter int OFFSET_W = 16
) (
  input  logic [FIELD_W-1:0]  midField,
  input  logic [FIELD_W-1:0]  lowField,
  input  fieldSel_t           fieldSel,
  output logic [FIELD_W-1:0]  opnd1Spec,
  output logic [FIELD_W-1:0]  opnd2Spec,
  output logic [FIELD_W-1:0]  maskVal,
  output logic [COND_W-1:0]   condCode,
  output logic [OFFSET_W-1:0] branchOffset
);

  localparam int EXT_W = OFFSET_W - DISP_W;

  logic [DISP_W-1:0] dispRaw;
  logic [COND_W-1:0] brCond;
  logic [COND_W-1:0] jmpCond;

  assign dispRaw = {midField[1:0], lowField};
  assign brCond  = midField[4:2];
  assign jmpCond = lowField[2:0];

  assign opnd1Spec = fieldSel.takeOp1  ? lowField : '0;
  assign opnd2Spec = fieldSel.takeOp2  ? midField : '0;
  assign maskVal   = fieldSel.takeMask ? lowField : '0;

  always_comb begin
    condCode = '0;
    if (fieldSel.takeBrCond)       condCode = brCond;
    else if (fieldSel.takeJmpCond) condCode = jmpCond;
  end

  generate
    if (EXT_W > 0) begin : g_ext
      assign branchOffset = fieldSel.takeDisp ? {{EXT_W{dispRaw[DISP_W-1]}}, dispRaw} : '0;
    end else begin : g_noext
      assign branchOffset = fieldSel.takeDisp ? dispRaw[OFFSET_W-1:0] : '0;
    end
  endgenerate

  // R7
  always_comb begin
    fld_cond_src_chk: assert (!(fieldSel.takeBrCond && fieldSel.takeJmpCond))
      else $error("two condition sources selected");
  end

endmodule

// File: rtl/instr_decoder_onehot.sv
module instr_decoder_onehot #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             enable,
  input  logic [IDX_W-1:0] index,
  output logic [N-1:0]     hot
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot[i] = enable && (index == IDX_W'(i));
  end

  // R11
  always_comb begin
    onehot_width_chk: assert ($onehot0(hot))
      else $error("strobe has more than one bit");
    if (enable) begin
      onehot_hit_chk: assert (hot[index])
        else $error("enabled strobe missing its bit");
    end
  end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_decoder_pkg::*;
#(
  parameter int OFFSET_W = 16
) (
  input  logic [15:0]         instrWord,
  output logic                isTwoOp,
  output logic                isOneOp,
  output logic                isZeroOp,
  output logic                isIllegal,
  output logic [31:0]         opStrobe,
  output logic [5:0]          opnd1Spec,
  output logic [5:0]          opnd2Spec,
  output logic [5:0]          maskVal,
  output logic [2:0]          condCode,
  output logic [OFFSET_W-1:0] branchOffset
);

  logic [TOP_W-1:0]   topField;
  logic [FIELD_W-1:0] midField;
  logic [FIELD_W-1:0] lowField;
  instrClass_t        instrClass;
  opId_t              opIdx;
  logic               opValid;
  fieldSel_t          fieldSel;

  assign topField = instrWord[15:12];
  assign midField = instrWord[11:6];
  assign lowField = instrWord[5:0];

  instr_decoder_ctrl u_ctrl (
    .topField  (topField),
    .midField  (midField),
    .lowField  (lowField),
    .instrClass(instrClass),
    .opIdx     (opIdx),
    .opValid   (opValid),
    .fieldSel  (fieldSel)
  );

  instr_decoder_fields #(.OFFSET_W(OFFSET_W)) u_fields (
    .midField    (midField),
    .lowField    (lowField),
    .fieldSel    (fieldSel),
    .opnd1Spec   (opnd1Spec),
    .opnd2Spec   (opnd2Spec),
    .maskVal     (maskVal),
    .condCode    (condCode),
    .branchOffset(branchOffset)
  );

  instr_decoder_onehot #(.N(NUM_OPS)) u_onehot (
    .enable(opValid),
    .index (opIdx),
    .hot   (opStrobe)
  );

  assign isTwoOp   = (instrClass == CLS_TWO);
  assign isOneOp   = (instrClass == CLS_ONE);
  assign isZeroOp  = (instrClass == CLS_ZERO);
  assign isIllegal = (instrClass == CLS_ILL);

  always_comb begin
    // R1
    class_onehot_chk: assert ($countones({isTwoOp, isOneOp, isZeroOp, isIllegal}) == 1)
      else $error("class outputs not one-hot");
    // R11
    strobe_class_chk: assert (($countones(opStrobe) == 1) == !isIllegal)
      else $error("strobe count disagrees with class");
    // R10
    if (isIllegal) begin
      illegal_quiet_chk: assert ({opnd1Spec, opnd2Spec, maskVal, condCode} == '0 && branchOffset == '0)
        else $error("illegal word drives a field");
    end
    // R2
    if (isTwoOp) begin
      two_op_top_chk: assert (instrWord[15:12] != 4'hF && opStrobe[15:9] == '0)
        else $error("two-operand class on wrong group");
    end
    // R8
    if (isZeroOp) begin
      zero_op_mid_chk: assert (instrWord[15:6] == 10'h3FF)
        else $error("zero-operand class without all-ones prefix");
    end
    // R7
    if (opStrobe[OP_BRA]) begin
      branch_ext_chk: assert (branchOffset[7:0] == instrWord[7:0] &&
                              branchOffset[OFFSET_W-1:8] == {(OFFSET_W-8){instrWord[7]}})
        else $error("branch offset not sign-extended low byte");
    end
  end

endmodule

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;

  logic        clk = 1'b0;
  logic [15:0] instrWord = '0;
  logic        isTwoOp, isOneOp, isZeroOp, isIllegal;
  logic [31:0] opStrobe;
  logic [5:0]  opnd1Spec, opnd2Spec, maskVal;
  logic [2:0]  condCode;
  logic [15:0] branchOffset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  instr_decoder u_dut (
    .instrWord   (instrWord),
    .isTwoOp     (isTwoOp),
    .isOneOp     (isOneOp),
    .isZeroOp    (isZeroOp),
    .isIllegal   (isIllegal),
    .opStrobe    (opStrobe),
    .opnd1Spec   (opnd1Spec),
    .opnd2Spec   (opnd2Spec),
    .maskVal     (maskVal),
    .condCode    (condCode),
    .branchOffset(branchOffset)
  );

  // cls: 0 two, 1 one, 2 zero, 3 illegal; op 63 = no strobe
  typedef struct packed {
    logic [15:0] w;
    logic [1:0]  cls;
    logic [5:0]  op;
    logic [5:0]  s1;
    logic [5:0]  s2;
    logic [5:0]  mask;
    logic [2:0]  cond;
    logic [15:0] off;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 2'd0, 6'd0,  6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd2},  // R2 LD
    '{16'h1A95, 2'd0, 6'd1,  6'h15, 6'h2A, 6'h00, 3'd0, 16'h0000, 4'd2},  // R2 ADD
    '{16'h8FFF, 2'd0, 6'd8,  6'h3F, 6'h3F, 6'h00, 3'd0, 16'h0000, 4'd2},  // R2 XOR
    '{16'h9000, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd3},  // R3
    '{16'hEFFF, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd3},  // R3
    '{16'hF00A, 2'd1, 6'd9,  6'h0A, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd4},  // R4 NOT
    '{16'hF321, 2'd1, 6'd21, 6'h21, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd4},  // R4 SRB
    '{16'hF340, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd5},  // R5 mid 13
    '{16'hF3C0, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd5},  // R5 mid 15
    '{16'hF42B, 2'd1, 6'd22, 6'h00, 6'h00, 6'h2B, 3'd0, 16'h0000, 4'd6},  // R6 mask-set
    '{16'hF47F, 2'd1, 6'd23, 6'h00, 6'h00, 6'h3F, 3'd0, 16'h0000, 4'd6},  // R6 trap
    '{16'hF480, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd5},  // R5 mid 18
    '{16'hF7C0, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd5},  // R5 mid 31
    '{16'hF87F, 2'd1, 6'd24, 6'h00, 6'h00, 6'h00, 3'd0, 16'h007F, 4'd7},  // R7 +127
    '{16'hFD80, 2'd1, 6'd24, 6'h00, 6'h00, 6'h00, 3'd5, 16'hFF80, 4'd7},  // R7 -128
    '{16'hFFBF, 2'd1, 6'd24, 6'h00, 6'h00, 6'h00, 3'd7, 16'hFFBF, 4'd7},  // R7 mid 62
    '{16'hFFC0, 2'd2, 6'd25, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd8},  // R8 SETC
    '{16'hFFC2, 2'd2, 6'd27, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd8},  // R8 RTS
    '{16'hFFC4, 2'd2, 6'd29, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd8},  // R8 NOP
    '{16'hFFC5, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd10}, // R10 low 5
    '{16'hFFDF, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd10}, // R10 low 31
    '{16'hFFE3, 2'd2, 6'd30, 6'h00, 6'h00, 6'h00, 3'd3, 16'h0000, 4'd9},  // R9 JMP
    '{16'hFFEE, 2'd2, 6'd31, 6'h00, 6'h00, 6'h00, 3'd6, 16'h0000, 4'd9},  // R9 JSR
    '{16'hFFF0, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd10}, // R10 11xxxx
    '{16'hFFFF, 2'd3, 6'd63, 6'h00, 6'h00, 6'h00, 3'd0, 16'h0000, 4'd10}  // R10 all ones
  };

  task automatic apply(input logic [15:0] w);
    @(posedge clk);
    instrWord = w;
    @(negedge clk);
  endtask

  function automatic logic [3:0] classBits();
    return {isIllegal, isZeroOp, isOneOp, isTwoOp};
  endfunction

  task automatic checkVec(input vec_t v);
    logic [3:0]  expCls;
    logic [31:0] expStb;
    logic [38:0] actF, expF;
    expCls = 4'b0001 << v.cls;
    expStb = (v.op == 6'd63) ? 32'h0 : (32'h1 << v.op);
    apply(v.w);
    checks++;
    if (classBits() != expCls) begin
      errors++;
      $display("FAIL R%0d class word=%h actual=%b expected=%b", v.req, v.w, classBits(), expCls);
    end
    checks++;
    if (opStrobe != expStb) begin
      errors++;
      $display("FAIL R%0d strobe word=%h actual=%h expected=%h", v.req, v.w, opStrobe, expStb);
    end
    // fields, including zero for unused ones (R11)
    actF = {opnd1Spec, opnd2Spec, maskVal, condCode, branchOffset};
    expF = {v.s1, v.s2, v.mask, v.cond, v.off};
    checks++;
    if (actF != expF) begin
      errors++;
      $display("FAIL R%0d fields word=%h actual=%h expected=%h", v.req, v.w, actF, expF);
    end
  endtask

  initial begin
    int r1Bad;
    int r11Bad;
    // initial word 0000 decodes as LD with empty specifiers (R2)
    @(negedge clk);
    checks++;
    if (!isTwoOp || opStrobe != 32'h1) begin
      errors++;
      $display("FAIL R2 initial decode actual=%b/%h expected=0001/00000001", classBits(), opStrobe);
    end

    for (int i = 0; i < NV; i++) checkVec(VECS[i]);

    // exhaustive sweep: class one-hot (R1), strobe consistent with class (R11)
    r1Bad = 0;
    r11Bad = 0;
    for (int w = 0; w < 65536; w++) begin
      apply(16'(w));
      if ($countones(classBits()) != 1) begin
        if (r1Bad == 0)
          $display("FAIL R1 word=%h actual=%b expected one bit set", 16'(w), classBits());
        r1Bad++;
      end
      if (($countones(opStrobe) == 1) != !isIllegal || (isIllegal && opStrobe != 0)) begin
        if (r11Bad == 0)
          $display("FAIL R11 word=%h actual strobe=%h illegal=%b expected one-hot iff legal",
                   16'(w), opStrobe, isIllegal);
        r11Bad++;
      end
    end
    checks += 2;
    if (r1Bad != 0) errors++;
    if (r11Bad != 0) errors++;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule